// File: doc/BRIEF.md
# Radix-4 Booth Partial-Product Recoder Row

This block turns one byte of a multiplier into four radix-4 Booth partial products of a 32-bit multiplicand. Every digit looks at a three-bit window of the multiplier and chooses one multiple of the multiplicand: zero, plus one, plus two, minus one or minus two. A negative multiple is not fully formed here. The block emits the bitwise complement of the positive multiple, and a separate correction bit stands for the missing +1. A later carry-save stage can then drop that bit into a free carry position, so no adder is needed at this point.

The multiplicand is widened to 34 bits before it is multiplied. A control input selects between unsigned operation (zero fill) and signed operation (sign fill). For this reason one downstream summing array can handle both kinds of multiply. The row is purely combinational. An iterating multiplier presents eight new multiplier bits each step, together with the multiplier bit just below them. On the first step that lower bit is 0. Shifting each partial product into its weight, summing the products, and sequencing the steps are left to the surrounding datapath.

Top module: `booth_recode_row`

## Requirements
- R1: A window of 3'b000 or 3'b111 gives an all-zero 34-bit word and a correction bit of 0.
- R2: Windows 3'b001 and 3'b010 give the extended multiplicand X as the word. Window 3'b011 gives 2X (X shifted left one place, bit 0 = 0). In all three the correction bit is 0.
- R3: Windows 3'b101 and 3'b110 give the bitwise complement of X as the word, with a correction bit of 1.
- R4: Window 3'b100 gives the bitwise complement of 2X, so word bit 0 is 1. The correction bit is 1, and word + 1 equals −2X modulo 2^34.
- R5: With is_signed = 0 the multiplicand is zero-extended to 34 bits. For a non-negative window, word bit 33 is therefore 0.
- R6: With is_signed = 1 the multiplicand is sign-extended to 34 bits. Bits 33 and 32 of X both copy x[31].
- R7: Digit i, for i = 0..3, uses the window {mul_slice[2i+1], mul_slice[2i], b}. Here b is mul_slice[2i−1] when i > 0, and mul_below when i = 0. Digit i occupies pp_word[34i+33:34i] and pp_neg[i].
- R8: For every digit, word + correction bit equals (mul_slice[2i] + b − 2·mul_slice[2i+1]) · X modulo 2^34, where b is as defined in R7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mul_slice | input | 8 | Eight multiplier bits handled by this row |
| mul_below | input | 1 | Multiplier bit just below the slice (0 for the lowest slice) |
| x | input | 32 | Multiplicand |
| is_signed | input | 1 | 1 = sign-extend the multiplicand, 0 = zero-extend |
| pp_word | output | 136 | Four 34-bit partial-product words, digit 0 in the low bits |
| pp_neg | output | 4 | Deferred +1 correction bit of each digit |

## Verification
The block holds no state, so any fault in the selection or extension logic shows on the outputs in the same evaluation as the input change that exposes it. A swapped multiple, an inversion applied before the doubling, or a wrong fill bit shows up as a mismatch in the sum of word and correction bit for the affected window. A window taken from the wrong multiplier bits affects only the digits that straddle a pair boundary. The bench therefore checks every digit of the row against the arithmetic value of its digit, and not only digit 0.

// File: rtl/booth_pkg.sv
package booth_pkg;

    localparam int MCAND_W  = 32;
    localparam int ROW_DIGS = 4;

    typedef enum logic [2:0] {
        SEL_ZERO = 3'd0,
        SEL_P1   = 3'd1,
        SEL_P2   = 3'd2,
        SEL_M1   = 3'd3,
        SEL_M2   = 3'd4
    } mult_sel_e;

    // Map a three-bit window {upper, middle, lower} onto a multiple choice.
    function automatic mult_sel_e classify(input logic [2:0] w);
        mult_sel_e s;
        unique case (w)
            3'b000, 3'b111: s = SEL_ZERO;
            3'b001, 3'b010: s = SEL_P1;
            3'b011:         s = SEL_P2;
            3'b100:         s = SEL_M2;
            default:        s = SEL_M1;
        endcase
        return s;
    endfunction

    function automatic logic is_negative(input mult_sel_e s);
        return (s == SEL_M1) || (s == SEL_M2);
    endfunction

    function automatic logic is_double(input mult_sel_e s);
        return (s == SEL_P2) || (s == SEL_M2);
    endfunction

endpackage

// File: rtl/booth_extend.sv
module booth_extend #(
    parameter int XW = booth_pkg::MCAND_W
) (
    input  logic [XW-1:0] x,
    input  logic          is_signed,
    output logic [XW+1:0] xe
);
    logic fill;

    always_comb begin
        fill = is_signed & x[XW-1];
        xe   = {{2{fill}}, x};
    end
endmodule

// File: rtl/booth_digit.sv
module booth_digit #(
    parameter int PW = booth_pkg::MCAND_W + 2
) (
    input  logic [2:0]    win,
    input  logic [PW-1:0] xe,
    output logic [PW-1:0] word,
    output logic          neg
);
    import booth_pkg::*;

    mult_sel_e     sel;
    logic [PW-1:0] mag;

    always_comb begin
        sel = classify(win);
        if (sel == SEL_ZERO) begin
            mag = '0;
        end else if (is_double(sel)) begin
            // Double first; any complement is applied afterwards.
            mag = {xe[PW-2:0], 1'b0};
        end else begin
            mag = xe;
        end
        neg  = is_negative(sel);
        word = neg ? ~mag : mag;
    end
endmodule

// File: rtl/booth_recode_row.sv
module booth_recode_row #(
    parameter int XW     = booth_pkg::MCAND_W,
    parameter int DIGITS = booth_pkg::ROW_DIGS
) (
    input  logic [2*DIGITS-1:0]          mul_slice,
    input  logic                         mul_below,
    input  logic [XW-1:0]                x,
    input  logic                         is_signed,
    output logic [DIGITS-1:0][XW+1:0]    pp_word,
    output logic [DIGITS-1:0]            pp_neg
);
    localparam int PW = XW + 2;
    localparam int EW = 2 * DIGITS + 1;

    logic [PW-1:0] xe;
    logic [EW-1:0] ext_bits;

    assign ext_bits = {mul_slice, mul_below};

    booth_extend #(.XW(XW)) u_ext (
        .x         (x),
        .is_signed (is_signed),
        .xe        (xe)
    );

    for (genvar i = 0; i < DIGITS; i++) begin : g_dig
        logic [2:0] win;
        assign win = ext_bits[2*i +: 3];

        booth_digit #(.PW(PW)) u_dig (
            .win  (win),
            .xe   (xe),
            .word (pp_word[i]),
            .neg  (pp_neg[i])
        );

        always_comb begin
            // R1
            if (win == 3'b000 || win == 3'b111) begin
                zero_window_chk: assert (pp_word[i] == '0 && !pp_neg[i]);
            end
            // R3
            if (pp_neg[i]) begin
                neg_needs_top_chk: assert (win[2] == 1'b1);
            end
            // R4
            if (win == 3'b100) begin
                dbl_neg_lsb_chk: assert (pp_word[i][0] && pp_neg[i]);
            end
            // R5
            if (!is_signed && !win[2]) begin
                unsigned_top_chk: assert (pp_word[i][PW-1] == 1'b0);
            end
            // R6
            if (is_signed && (win == 3'b001 || win == 3'b010)) begin
                signed_fill_chk: assert (pp_word[i][PW-1] == x[XW-1] &&
                                         pp_word[i][PW-2] == x[XW-1]);
            end
        end
    end
endmodule

// File: tb/tb_booth_recode_row.sv
module tb_booth_recode_row;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [7:0]        mul_slice;
    logic              mul_below;
    logic [31:0]       x;
    logic              is_signed;
    logic [3:0][33:0]  pp_word;
    logic [3:0]        pp_neg;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    booth_recode_row dut (
        .mul_slice (mul_slice),
        .mul_below (mul_below),
        .x         (x),
        .is_signed (is_signed),
        .pp_word   (pp_word),
        .pp_neg    (pp_neg)
    );

    function automatic string class_tag(input logic [2:0] w);
        case (w)
            3'b000, 3'b111:         return "R1";
            3'b001, 3'b010, 3'b011: return "R2";
            3'b100:                 return "R4";
            default:                return "R3";
        endcase
    endfunction

    // Drive at a rising edge, sample at the following falling edge.
    task automatic apply_and_check(input logic [7:0] s, input logic b,
                                   input logic [31:0] xv, input logic sg,
                                   input string tag);
        logic [8:0]  ext;
        logic [33:0] xe, pos, ew, prod;
        logic        en;
        int          d;
        @(posedge clk);
        mul_slice = s; mul_below = b; x = xv; is_signed = sg;
        @(negedge clk);
        ext = {s, b};
        xe  = sg ? {{2{xv[31]}}, xv} : {2'b00, xv};
        for (int i = 0; i < 4; i++) begin
            logic [2:0] w;
            w = ext[2*i +: 3];
            d = int'(w[1]) + int'(w[0]) - 2 * int'(w[2]);
            case (d)
                0:       begin pos = '0;      prod = '0;          end
                1:       begin pos = xe;      prod = xe;          end
                2:       begin pos = xe << 1; prod = xe << 1;     end
                -1:      begin pos = xe;      prod = -xe;         end
                default: begin pos = xe << 1; prod = -(xe << 1);  end
            endcase
            en = (d < 0);
            ew = en ? ~pos : pos;
            checks++;
            if (pp_word[i] !== ew) begin
                errors++;
                $display("FAIL %s/%s digit %0d word: got %h expected %h",
                         tag, class_tag(w), i, pp_word[i], ew);
            end
            checks++;
            if (pp_neg[i] !== en) begin
                errors++;
                $display("FAIL %s/%s digit %0d neg: got %b expected %b",
                         tag, class_tag(w), i, pp_neg[i], en);
            end
            checks++;
            if (34'(pp_word[i] + 34'(pp_neg[i])) !== prod) begin
                errors++;
                $display("FAIL %s/R8 digit %0d sum: got %h expected %h",
                         tag, i, 34'(pp_word[i] + 34'(pp_neg[i])), prod);
            end
        end
    endtask

    task automatic t_idle();
        apply_and_check(8'h00, 1'b0, 32'h0, 1'b0, "R1");
    endtask

    task automatic t_each_window();
        for (int w = 0; w < 8; w++) begin
            logic [2:0] wb;
            wb = 3'(w);
            apply_and_check({6'b0, wb[2:1]}, wb[0], 32'h1234_5679, 1'b0, "R8");
            apply_and_check({6'b0, wb[2:1]}, wb[0], 32'hC0DE_0F13, 1'b1, "R8");
        end
    endtask

    task automatic t_unsigned_fill();
        apply_and_check(8'b0110_0110, 1'b1, 32'hFFFF_FFFF, 1'b0, "R5");
        apply_and_check(8'b1001_1001, 1'b0, 32'h8000_0000, 1'b0, "R5");
    endtask

    task automatic t_signed_fill();
        apply_and_check(8'b0110_0110, 1'b1, 32'h8000_0001, 1'b1, "R6");
        apply_and_check(8'b1001_1001, 1'b0, 32'hFFFF_FFFE, 1'b1, "R6");
        apply_and_check(8'b0011_0011, 1'b0, 32'h7FFF_FFFF, 1'b1, "R6");
    endtask

    task automatic t_double_neg();
        apply_and_check(8'b0000_0010, 1'b0, 32'h7FFF_FFFF, 1'b0, "R4");
        apply_and_check(8'b0000_0010, 1'b0, 32'hFFFF_FFFF, 1'b1, "R4");
        apply_and_check(8'b0000_0010, 1'b0, 32'h0000_0001, 1'b1, "R4");
    endtask

    task automatic t_window_map();
        apply_and_check(8'hFF, 1'b0, 32'h0000_0001, 1'b0, "R7");
        apply_and_check(8'h01, 1'b1, 32'h0000_00A5, 1'b0, "R7");
        apply_and_check(8'h80, 1'b0, 32'h0F0F_0F0F, 1'b1, "R7");
        apply_and_check(8'b0101_0100, 1'b1, 32'h3333_3333, 1'b0, "R7");
    endtask

    task automatic t_random();
        for (int k = 0; k < 200; k++) begin
            apply_and_check(8'($urandom), 1'($urandom), $urandom, 1'($urandom), "R8");
        end
    endtask

    initial begin
        mul_slice = '0; mul_below = 1'b0; x = '0; is_signed = 1'b0;
        repeat (2) @(posedge clk);
        t_idle();
        t_each_window();
        t_unsigned_fill();
        t_signed_fill();
        t_double_neg();
        t_window_map();
        t_random();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule